// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

This block merges the memory type and shareability produced by a first translation stage with the matching fields of a second stage, and returns the single attribute and shareability to report for the whole translation. The first-stage attribute is an 8-bit value. Its upper nibble holds the outer cacheability and its lower nibble holds the inner cacheability. The second stage supplies a 4-bit memory-type code and a 2-bit shareability field taken from its descriptor.

There are two ways to read the second-stage code. In the default mode it is expanded to a full 8-bit attribute, and the two stages are then combined. Any Device type takes precedence. Otherwise each nibble is downgraded to the weaker of the two cacheability classes. In the forced-write-back mode the code instead chooses whether the result is a Device type, a fixed non-cacheable or write-back value, or the unchanged first-stage attribute. A cache-disable input then forces every Normal result to non-cacheable.

The block has one register stage. Operands presented with the input valid appear on the outputs one clock later.

Top module: `s12_attr_merge`

## Requirements
- R1: An attribute whose upper nibble is 0 is Device. In the default mode, when either the first-stage attribute or the expanded second-stage attribute is Device, the result is the numerically smaller of the two 8-bit values.
- R2: In the default mode the second-stage code expands as follows:
  - 00xx becomes 0x0 with xx in bits [3:2] of the attribute.
  - 0100 becomes 0xCC.
  - 1000 and 1100 become 0x44.
  - Any other code becomes outer class code[3:2] and inner class code[1:0], each placed in bits [3:2] of its nibble with 00 in bits [1:0].
- R3: When both sides are Normal, each nibble is combined on its own using class bits [3:2]. If either side has class 01 (non-cacheable), the nibble is 0100. Otherwise, if either side has class 10 (write-through), the class is 10. Otherwise the class is 11 (write-back). A cacheable result takes bits [1:0] of the first-stage nibble.
- R4: A first-stage nibble of 0001 to 0011 is promoted to 1001 to 1011 before combining. A nibble of 0101 to 0111 is promoted to 1101 to 1111.
- R5: In forced-write-back mode, code 0101 passes through a Device first-stage attribute and otherwise gives 0x44.
- R6: In forced-write-back mode:
  - Codes 0110 and 1110 give 0xFF.
  - Codes 0100, 0111, 1100, 1101 and 1111 give the first-stage attribute.
  - Any code with bit 2 clear gives 0x0 with code[1:0] in bits [3:2].
- R7: When cache disable is high and the selected attribute is not Device, the result is 0x44.
- R8: The effective second-stage shareability depends on the final attribute:
  - If the final attribute is Device or 0x44, it is 10 (outer).
  - Otherwise a raw field of 01 becomes 00 (non-shareable), and any other raw value is used unchanged.
- R9: The output shareability is 10 if either side is 10. Otherwise it is 11 (inner) if either side is 11. Otherwise it is 00.
- R10: Output valid equals input valid delayed by one clock. Reset clears output valid, the attribute and the shareability to 0.
- R11: While input valid is low, the attribute and shareability outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands valid |
| s1_attr_i | input | 8 | First-stage attribute, outer nibble high |
| s1_sh_i | input | 2 | First-stage shareability |
| s2_mattr_i | input | 4 | Second-stage memory-type code |
| s2_sh_i | input | 2 | Raw second-stage shareability field |
| fwb_mode_i | input | 1 | Selects forced-write-back interpretation |
| cache_dis_i | input | 1 | Forces Normal results to non-cacheable |
| out_valid_o | output | 1 | Result valid |
| attr_o | output | 8 | Final attribute |
| sh_o | output | 2 | Final shareability |

## Verification
The bench runs every combination of first-stage attribute and second-stage code, in both modes and with cache disable both off and on. This separates four things:
- results where Device precedence decides;
- results where only the per-nibble class downgrade decides;
- results that depend on transient promotion, which only nibbles 0001 to 0111 expose;
- results that depend on the alternative code table.

The shareability inputs cycle through all sixteen pairs within that sweep. Each pair therefore meets Device, non-cacheable and cacheable outcomes, which separates the outer-shareable override from the reserved-value mapping and from the priority order. Idle cycles are inserted at intervals to show that the outputs hold while input valid is low.

// File: rtl/s12_attr_pkg.sv
package s12_attr_pkg;
  localparam int ATTR_W = 8;
  localparam int NIB_W  = 4;
  localparam int NIBS   = ATTR_W / NIB_W;
  localparam int CODE_W = 4;
  localparam int SH_W   = 2;

  typedef enum logic [1:0] {
    CAT_DEV = 2'b00,
    CAT_NC  = 2'b01,
    CAT_WT  = 2'b10,
    CAT_WB  = 2'b11
  } cat_e;

  localparam logic [SH_W-1:0] SH_NON = 2'b00;
  localparam logic [SH_W-1:0] SH_RSV = 2'b01;
  localparam logic [SH_W-1:0] SH_OUT = 2'b10;
  localparam logic [SH_W-1:0] SH_INN = 2'b11;

  localparam logic [ATTR_W-1:0] ATTR_NCNC   = 8'h44;
  localparam logic [ATTR_W-1:0] ATTR_WBWB   = 8'hCC;
  localparam logic [ATTR_W-1:0] ATTR_WBRAWA = 8'hFF;

  function automatic logic is_dev(input logic [ATTR_W-1:0] a);
    return a[ATTR_W-1 -: NIB_W] == '0;
  endfunction
endpackage

// File: rtl/s2_attr_expand.sv
module s2_attr_expand
  import s12_attr_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [ATTR_W-1:0] attr_o
);
  always_comb begin
    if (code_i[3:2] == 2'b00) begin
      attr_o = {{NIB_W{1'b0}}, code_i[1:0], 2'b00};
    end else if (code_i[1:0] == 2'b00) begin
      // 0100 is write-back both ways; 1000 and 1100 are reserved
      attr_o = (code_i[3:2] == 2'b01) ? ATTR_WBWB : ATTR_NCNC;
    end else begin
      attr_o = {code_i[3:2], 2'b00, code_i[1:0], 2'b00};
    end
  end
endmodule

// File: rtl/nibble_merge.sv
module nibble_merge
  import s12_attr_pkg::*;
(
  input  logic [NIB_W-1:0] s1_nib_i,
  input  logic [NIB_W-1:0] s2_nib_i,
  output logic [NIB_W-1:0] nib_o
);
  logic             transient;
  logic [NIB_W-1:0] promo;
  cat_e             c1, c2, cat;

  assign transient = ~s1_nib_i[3] & (s1_nib_i[1:0] != 2'b00);
  assign promo     = transient ? {1'b1, s1_nib_i[2:0]} : s1_nib_i;
  assign c1        = cat_e'(promo[3:2]);
  assign c2        = cat_e'(s2_nib_i[3:2]);

  always_comb begin
    if (c1 == CAT_NC || c2 == CAT_NC) begin
      cat   = CAT_NC;
      nib_o = {CAT_NC, 2'b00};
    end else begin
      cat   = (c1 == CAT_WT || c2 == CAT_WT) ? CAT_WT : CAT_WB;
      nib_o = {cat, promo[1:0]};
    end
  end
endmodule

// File: rtl/fwb_attr_map.sv
module fwb_attr_map
  import s12_attr_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [ATTR_W-1:0] s1_attr_i,
  output logic [ATTR_W-1:0] attr_o
);
  always_comb begin
    unique case (code_i)
      4'b0101:                   attr_o = is_dev(s1_attr_i) ? s1_attr_i : ATTR_NCNC;
      4'b0110, 4'b1110:          attr_o = ATTR_WBRAWA;
      4'b0111, 4'b1111,
      4'b0100, 4'b1100, 4'b1101: attr_o = s1_attr_i;
      default:                   attr_o = {{NIB_W{1'b0}}, code_i[1:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/sh_merge.sv
module sh_merge
  import s12_attr_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [SH_W-1:0]   s1_sh_i,
  input  logic [SH_W-1:0]   s2_raw_i,
  output logic [SH_W-1:0]   sh_o
);
  logic [SH_W-1:0] s2_eff;

  always_comb begin
    if (is_dev(attr_i) || attr_i == ATTR_NCNC) s2_eff = SH_OUT;
    else if (s2_raw_i == SH_RSV)               s2_eff = SH_NON;
    else                                       s2_eff = s2_raw_i;

    if (s1_sh_i == SH_OUT || s2_eff == SH_OUT)      sh_o = SH_OUT;
    else if (s1_sh_i == SH_INN || s2_eff == SH_INN) sh_o = SH_INN;
    else                                            sh_o = SH_NON;
  end
endmodule

// File: rtl/s12_attr_merge.sv
module s12_attr_merge
  import s12_attr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ATTR_W-1:0] s1_attr_i,
  input  logic [SH_W-1:0]   s1_sh_i,
  input  logic [CODE_W-1:0] s2_mattr_i,
  input  logic [SH_W-1:0]   s2_sh_i,
  input  logic              fwb_mode_i,
  input  logic              cache_dis_i,
  output logic              out_valid_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [SH_W-1:0]   sh_o
);
  logic [ATTR_W-1:0] s2_exp, mem_attr, std_attr, fwb_attr, sel_attr, fin_attr;
  logic [SH_W-1:0]   fin_sh;

  s2_attr_expand u_exp (.code_i(s2_mattr_i), .attr_o(s2_exp));

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    nibble_merge u_nib (
      .s1_nib_i(s1_attr_i[g*NIB_W +: NIB_W]),
      .s2_nib_i(s2_exp[g*NIB_W +: NIB_W]),
      .nib_o   (mem_attr[g*NIB_W +: NIB_W])
    );
  end

  fwb_attr_map u_fwb (.code_i(s2_mattr_i), .s1_attr_i(s1_attr_i), .attr_o(fwb_attr));

  always_comb begin
    if (is_dev(s1_attr_i) || is_dev(s2_exp))
      std_attr = (s1_attr_i < s2_exp) ? s1_attr_i : s2_exp;
    else
      std_attr = mem_attr;
    sel_attr = fwb_mode_i ? fwb_attr : std_attr;
    fin_attr = (cache_dis_i && !is_dev(sel_attr)) ? ATTR_NCNC : sel_attr;
  end

  sh_merge u_sh (.attr_i(fin_attr), .s1_sh_i(s1_sh_i), .s2_raw_i(s2_sh_i), .sh_o(fin_sh));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      attr_o      <= '0;
      sh_o        <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        attr_o <= fin_attr;
        sh_o   <= fin_sh;
      end
    end
  end
endmodule

// File: rtl/s12_attr_merge_chk.sv
module s12_attr_merge_chk
  import s12_attr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [ATTR_W-1:0] s1_attr_i,
  input logic [CODE_W-1:0] s2_mattr_i,
  input logic              fwb_mode_i,
  input logic              cache_dis_i,
  input logic              out_valid_o,
  input logic [ATTR_W-1:0] attr_o,
  input logic [SH_W-1:0]   sh_o
);
  p_valid_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(attr_o) && $stable(sh_o)));
  p_dev_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !fwb_mode_i && s1_attr_i[7:4] == 4'h0) |=> attr_o[7:4] == 4'h0);
  p_fwb_rawa_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && fwb_mode_i && !cache_dis_i && s2_mattr_i == 4'b0110) |=> attr_o == 8'hFF);
  p_cd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cache_dis_i) |=> (attr_o[7:4] == 4'h0 || attr_o == 8'h44));
  p_osh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (attr_o[7:4] == 4'h0 || attr_o == 8'h44)) |-> sh_o == 2'b10);
  p_no_rsv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sh_o != 2'b01);
endmodule

bind s12_attr_merge s12_attr_merge_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .s1_attr_i(s1_attr_i),
  .s2_mattr_i(s2_mattr_i), .fwb_mode_i(fwb_mode_i), .cache_dis_i(cache_dis_i),
  .out_valid_o(out_valid_o), .attr_o(attr_o), .sh_o(sh_o)
);

// File: tb/s12_attr_merge_tb_top.sv
`timescale 1ns/1ps
module s12_attr_merge_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] s1_attr_i = '0;
  logic [1:0] s1_sh_i = '0;
  logic [3:0] s2_mattr_i = '0;
  logic [1:0] s2_sh_i = '0;
  logic       fwb_mode_i = 1'b0;
  logic       cache_dis_i = 1'b0;
  logic       out_valid_o;
  logic [7:0] attr_o;
  logic [1:0] sh_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int last_a = 0;
  int last_s = 0;

  always #2.5 clk_i = ~clk_i;

  s12_attr_merge dut_i (.*);

  function automatic int mix(int a, int b);
    int ca, cb;
    if ((a >= 1 && a <= 3) || (a >= 5 && a <= 7)) a = a + 8;  // R4 promotion
    ca = a / 4;
    cb = b / 4;
    if (ca == 1 || cb == 1) return 4;
    return ((ca == 2 || cb == 2) ? 8 : 12) + a % 4;
  endfunction

  function automatic int expand(int c);
    if (c < 4) return c * 4;
    if (c == 4) return 'hCC;
    if (c % 4 == 0) return 'h44;
    return (c / 4) * 64 + (c % 4) * 4;
  endfunction

  function automatic int ref_attr(int s1, int c, bit fwb, bit cd);
    int r, e;
    if (fwb) begin
      if (c == 5) r = (s1 < 16) ? s1 : 'h44;
      else if (c == 6 || c == 14) r = 'hFF;
      else if (c == 4 || c == 7 || c == 12 || c == 13 || c == 15) r = s1;
      else r = (c % 4) * 4;
    end else begin
      e = expand(c);
      if (s1 < 16 || e < 16) r = (s1 < e) ? s1 : e;
      else r = mix(s1 / 16, e / 16) * 16 + mix(s1 % 16, e % 16);
    end
    if (cd && r >= 16) r = 'h44;
    return r;
  endfunction

  function automatic int ref_sh(int a, int s1s, int raw);
    int e;
    if (a < 16 || a == 'h44) e = 2;
    else e = (raw == 1) ? 0 : raw;
    if (s1s == 2 || e == 2) return 2;
    if (s1s == 3 || e == 3) return 3;
    return 0;
  endfunction

  function automatic string tag_of(int s1, int c, bit fwb, bit cd);
    if (fwb) return (c == 5) ? "R5" : "R6";
    if (cd) return "R7";
    if (s1 < 16 || expand(c) < 16) return "R1";
    if ((s1 % 16) inside {[1:3], [5:7]} || (s1 / 16) inside {[1:3], [5:7]}) return "R4";
    return "R3";
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic apply(bit v, int s1, int s1s, int c, int raw, bit fwb, bit cd, string tag);
    int ea;
    @(negedge clk_i);
    in_valid_i = v; s1_attr_i = 8'(s1); s1_sh_i = 2'(s1s);
    s2_mattr_i = 4'(c); s2_sh_i = 2'(raw); fwb_mode_i = fwb; cache_dis_i = cd;
    @(posedge clk_i);
    #1;
    chk("R10", int'(out_valid_o), int'(v));
    if (v) begin
      ea = ref_attr(s1, c, fwb, cd);
      chk(tag, int'(attr_o), ea);
      chk("R9", int'(sh_o), ref_sh(ea, s1s, raw));
      last_a = ea;
      last_s = ref_sh(ea, s1s, raw);
    end else begin
      chk("R11", int'(attr_o), last_a);
      chk("R11", int'(sh_o), last_s);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R10", int'(out_valid_o), 0);
    chk("R10", int'(attr_o), 0);
    chk("R10", int'(sh_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: full-strength first stage shows each second-stage expansion
    for (int c = 0; c < 16; c++) apply(1, 'hFF, 0, c, 0, 0, 0, "R2");
    apply(1, 'h04, 3, 0, 3, 0, 0, "R1");
    apply(1, 'h15, 0, 15, 0, 0, 0, "R4");
    apply(0, 'h88, 1, 9, 1, 1, 1, "R11");
    apply(1, 'hEE, 1, 9, 1, 0, 0, "R3");
    apply(1, 'hAA, 0, 5, 3, 1, 0, "R5");
    apply(1, 'h08, 0, 5, 3, 1, 0, "R5");
    apply(1, 'hCC, 1, 3, 1, 0, 0, "R8");
    for (int i = 0; i < 16384; i++) begin
      int s1, c;
      bit fwb, cd;
      s1 = i % 256; c = (i / 256) % 16; fwb = i[12]; cd = i[13];
      apply(1, s1, i % 4, c, (i / 4) % 4, fwb, cd, tag_of(s1, c, fwb, cd));
      if (i % 37 == 0) apply(0, (i * 7) % 256, 2, i % 16, 3, ~fwb, ~cd, "R11");
    end
    apply(0, 0, 0, 0, 0, 0, 0, "R11");
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog expired got 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule